// File: doc/BRIEF.md
# Shared SRAM Bridge with Prefetch

This block places a byte-wide SRAM of up to 64 Kbytes, sitting on a private bus, into a 16-bit host memory window. The host always sees 16-bit cycles. Host writes are posted: the word and its address land in a one-word holding register, the host cycle ends at once, and the bridge later writes the word to the SRAM as two byte writes.

Host reads are answered from a one-word prefetch buffer tagged with its word address. A read that misses stalls the host while two bytes are fetched. A read that hits is answered with no wait state. Once the read strobe drops, the bridge refills the buffer from the next word address, so a host walking upward through memory keeps hitting. Any other private-bus activity, signalled on an invalidate input, discards the buffered word.

The bridge requests the private bus and only drives bus strobes while the grant is present. Outputs toward the host (`host_ready`, `host_rdata`, `host_rdata_en`) are registered and change on the clock edge after the condition that moves them.

Top module: `shm_bridge`

## Requirements
- R1: After reset, `host_ready` is 1, `host_rdata_en` is 0, and `pb_req`, `pb_rd` and `pb_wr` are 0. The holding register is empty and the prefetch buffer is invalid.
- R2: A host write that finds the holding register empty is captured on the first clock edge, and `host_ready` never goes low during that write.
- R3: A held word w is written to the SRAM with no host involvement. The low byte goes to byte address 2w and the high byte to 2w+1.
- R4: A host write that finds the holding register full drives `host_ready` low from the next edge until the earlier word has been written to the SRAM. The write is then captured and `host_ready` returns to 1.
- R5: While a host read is outstanding, `pb_req` is 1 and `host_ready` stays low as long as `pb_gnt` is 0. `pb_rd` and `pb_wr` are only ever 1 while `pb_gnt` is 1.
- R6: A read whose word is not in the buffer holds `host_ready` low while two SRAM bytes are read. It then returns the current SRAM word.
- R7: A read whose word is already valid in the buffer is answered with no wait state.
- R8: When the read strobe drops after word w was returned, the buffer is refilled with word w+1, wrapping from the last word of the window to word 0.
- R9: A pulse on `pb_inval` invalidates the buffer. The next read of that word fetches it again and returns the SRAM's present content.
- R10: A read of a word that the host has just written returns the new value, even while the write is still posted.
- R11: A returned word stays on `host_rdata` with `host_rdata_en` at 1, unchanged, until the read strobe drops. `host_rdata_en` goes to 0 on the following edge.
- R12: Strobes are ignored while `host_refresh` is 1 or `host_sel` is 0. No SRAM write takes place, no data is driven, and `host_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W-1 | Host word address within the window |
| host_sel | input | 1 | Window select from external address decode |
| host_rd | input | 1 | Host memory read strobe |
| host_wr | input | 1 | Host memory write strobe |
| host_refresh | input | 1 | Refresh cycle in progress; blocks host cycles |
| host_wdata | input | 2*BYTE_W | Host write word |
| host_rdata | output | 2*BYTE_W | Host read word |
| host_rdata_en | output | 1 | Read word is being driven |
| host_ready | output | 1 | 0 inserts wait states into the host cycle |
| pb_req | output | 1 | Private-bus request |
| pb_gnt | input | 1 | Private-bus grant |
| pb_addr | output | ADDR_W | SRAM byte address |
| pb_wdata | output | BYTE_W | SRAM write byte |
| pb_rdata | input | BYTE_W | SRAM read byte, valid the cycle after `pb_rd` |
| pb_rd | output | 1 | SRAM byte read strobe |
| pb_wr | output | 1 | SRAM byte write strobe |
| pb_inval | input | 1 | Other private-bus activity; drops the buffered word |

## Verification
A buffer left valid when it should not be shows up at the ports in one way: the next read of that word returns with zero waits and an old value. The bench therefore pairs every read with a wait count and a data compare, after writes, after an invalidate pulse, and after SRAM content changes behind the bridge. A holding register that loses or misorders a word shows as wrong bytes at 2w and 2w+1 a few cycles after the write. A missing stall on a full register shows as a write with zero waits while the grant is withheld. A prefetch that does not advance, or that fails to wrap, turns the sequential sweep's zero-wait reads into waited reads on the very next access.

// File: rtl/shm_pkg.sv
package shm_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WLO,
    SQ_WHI,
    SQ_RLO,
    SQ_RHI,
    SQ_RFIN
  } shm_state_e;
endpackage

// File: rtl/shm_hold.sv
module shm_hold #(
  parameter int AW = 15,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic          drain_done,
  input  logic [AW-1:0] cap_addr,
  input  logic [DW-1:0] cap_data,
  output logic          full,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (cap) begin
      full <= 1'b1;
    end else if (drain_done) begin
      full <= 1'b0;
    end
    if (cap) begin
      addr <= cap_addr;
      data <= cap_data;
    end
  end

  // R4: a new word is only taken into an empty register
  a_r4_cap_when_empty: assert property (@(posedge clk) disable iff (rst)
    cap |-> !full);
  // R3: only a held word can be reported as written
  a_r3_drain_needs_word: assert property (@(posedge clk) disable iff (rst)
    drain_done |-> full);
endmodule

// File: rtl/shm_pfbuf.sv
module shm_pfbuf #(
  parameter int AW = 15,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fill_start,
  input  logic          fill_active,
  input  logic          fill_done,
  input  logic [AW-1:0] fill_tag,
  input  logic [DW-1:0] fill_data,
  input  logic          inval,
  output logic          valid,
  output logic [AW-1:0] tag,
  output logic [DW-1:0] data
);
  logic spoil;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      spoil <= 1'b0;
    end else begin
      if (fill_start) begin
        valid <= 1'b0;
        spoil <= 1'b0;
      end else if (fill_done) begin
        valid <= !(spoil || inval);
      end else if (inval) begin
        valid <= 1'b0;
      end
      if (fill_active && inval) spoil <= 1'b1;
    end
    if (fill_done) begin
      tag  <= fill_tag;
      data <= fill_data;
    end
  end

  // R9: foreign bus activity leaves no valid word behind
  a_r9_inval_clears: assert property (@(posedge clk) disable iff (rst)
    inval |=> !valid);
endmodule

// File: rtl/shm_seq.sv
module shm_seq import shm_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  localparam int WORD_W = ADDR_W - 1,
  localparam int DW = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gnt,
  input  logic              hold_full,
  input  logic [WORD_W-1:0] hold_addr,
  input  logic [DW-1:0]     hold_data,
  input  logic              demand_req,
  input  logic [WORD_W-1:0] demand_addr,
  input  logic              pf_req,
  input  logic [WORD_W-1:0] pf_addr,
  input  logic [BYTE_W-1:0] pb_rdata,
  output logic              pb_rd,
  output logic              pb_wr,
  output logic [ADDR_W-1:0] pb_addr,
  output logic [BYTE_W-1:0] pb_wdata,
  output logic              busy,
  output logic              hold_drained,
  output logic              fill_start,
  output logic              fill_active,
  output logic              fill_done,
  output logic              pf_taken,
  output logic [WORD_W-1:0] fill_tag,
  output logic [DW-1:0]     fill_data
);
  shm_state_e        state, next;
  logic [WORD_W-1:0] job_addr;
  logic [BYTE_W-1:0] lo_byte;
  logic              lo_wait;

  always_comb begin
    next         = state;
    pb_rd        = 1'b0;
    pb_wr        = 1'b0;
    pb_addr      = '0;
    pb_wdata     = '0;
    hold_drained = 1'b0;
    fill_start   = 1'b0;
    fill_done    = 1'b0;
    pf_taken     = 1'b0;
    case (state)
      SQ_IDLE: begin
        if (hold_full) begin
          next = SQ_WLO;
        end else if (demand_req) begin
          next       = SQ_RLO;
          fill_start = 1'b1;
        end else if (pf_req) begin
          next       = SQ_RLO;
          fill_start = 1'b1;
          pf_taken   = 1'b1;
        end
      end
      SQ_WLO: begin
        pb_addr  = {hold_addr, 1'b0};
        pb_wdata = hold_data[BYTE_W-1:0];
        if (gnt) begin
          pb_wr = 1'b1;
          next  = SQ_WHI;
        end
      end
      SQ_WHI: begin
        pb_addr  = {hold_addr, 1'b1};
        pb_wdata = hold_data[DW-1:BYTE_W];
        if (gnt) begin
          pb_wr        = 1'b1;
          hold_drained = 1'b1;
          next         = SQ_IDLE;
        end
      end
      SQ_RLO: begin
        pb_addr = {job_addr, 1'b0};
        if (gnt) begin
          pb_rd = 1'b1;
          next  = SQ_RHI;
        end
      end
      SQ_RHI: begin
        pb_addr = {job_addr, 1'b1};
        if (gnt) begin
          pb_rd = 1'b1;
          next  = SQ_RFIN;
        end
      end
      SQ_RFIN: begin
        fill_done = 1'b1;
        next      = SQ_IDLE;
      end
      default: next = SQ_IDLE;
    endcase
  end

  assign busy        = (state != SQ_IDLE);
  assign fill_active = (state == SQ_RLO) || (state == SQ_RHI) || (state == SQ_RFIN);
  assign fill_tag    = job_addr;
  assign fill_data   = {pb_rdata, lo_byte};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      lo_wait <= 1'b0;
    end else begin
      state   <= next;
      lo_wait <= (state == SQ_RLO) && gnt;
    end
    if (fill_start) job_addr <= demand_req ? demand_addr : pf_addr;
    if (state == SQ_RHI && lo_wait) lo_byte <= pb_rdata;
  end
endmodule

// File: rtl/shm_bridge.sv
module shm_bridge import shm_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  localparam int WORD_W = ADDR_W - 1,
  localparam int DW = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] host_addr,
  input  logic              host_sel,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_refresh,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              host_rdata_en,
  output logic              host_ready,
  output logic              pb_req,
  input  logic              pb_gnt,
  output logic [ADDR_W-1:0] pb_addr,
  output logic [BYTE_W-1:0] pb_wdata,
  input  logic [BYTE_W-1:0] pb_rdata,
  output logic              pb_rd,
  output logic              pb_wr,
  input  logic              pb_inval
);
  logic              rd_act, wr_act, cap, serve_now, demand, stale, hit;
  logic              wr_taken, serving, pf_pend;
  logic [WORD_W-1:0] last_addr, pf_next;
  logic              h_full;
  logic [WORD_W-1:0] h_addr;
  logic [DW-1:0]     h_data;
  logic              b_valid;
  logic [WORD_W-1:0] b_tag;
  logic [DW-1:0]     b_data;
  logic              seq_busy, h_drained, f_start, f_active, f_done, pf_taken;
  logic [WORD_W-1:0] f_tag;
  logic [DW-1:0]     f_data;
  logic              inval_any;

  assign rd_act    = host_sel && host_rd && !host_refresh;
  assign wr_act    = host_sel && host_wr && !host_refresh;
  assign cap       = wr_act && !wr_taken && !h_full;
  assign stale     = h_full && (h_addr == host_addr);
  assign hit       = b_valid && (b_tag == host_addr) && !stale;
  assign serve_now = rd_act && !serving && hit && pb_gnt;
  assign demand    = rd_act && !serving && !hit;
  assign pb_req    = seq_busy || h_full || (rd_act && !serving) || pf_pend;
  assign inval_any = pb_inval || pb_wr;

  shm_hold #(.AW(WORD_W), .DW(DW)) i_hold (
    .clk(clk), .rst(rst), .cap(cap), .drain_done(h_drained),
    .cap_addr(host_addr), .cap_data(host_wdata),
    .full(h_full), .addr(h_addr), .data(h_data)
  );

  shm_pfbuf #(.AW(WORD_W), .DW(DW)) i_pfbuf (
    .clk(clk), .rst(rst), .fill_start(f_start), .fill_active(f_active),
    .fill_done(f_done), .fill_tag(f_tag), .fill_data(f_data),
    .inval(inval_any), .valid(b_valid), .tag(b_tag), .data(b_data)
  );

  shm_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_seq (
    .clk(clk), .rst(rst), .gnt(pb_gnt),
    .hold_full(h_full), .hold_addr(h_addr), .hold_data(h_data),
    .demand_req(demand), .demand_addr(host_addr),
    .pf_req(pf_pend), .pf_addr(pf_next), .pb_rdata(pb_rdata),
    .pb_rd(pb_rd), .pb_wr(pb_wr), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
    .busy(seq_busy), .hold_drained(h_drained), .fill_start(f_start),
    .fill_active(f_active), .fill_done(f_done), .pf_taken(pf_taken),
    .fill_tag(f_tag), .fill_data(f_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_taken      <= 1'b0;
      serving       <= 1'b0;
      pf_pend       <= 1'b0;
      host_ready    <= 1'b1;
      host_rdata_en <= 1'b0;
      host_rdata    <= '0;
      last_addr     <= '0;
      pf_next       <= '0;
    end else begin
      wr_taken   <= cap || (wr_taken && wr_act);
      host_ready <= !((wr_act && !wr_taken && !cap) ||
                      (rd_act && !serving && !serve_now));
      if (serve_now) begin
        serving       <= 1'b1;
        host_rdata_en <= 1'b1;
        host_rdata    <= b_data;
        last_addr     <= host_addr;
      end else if (serving && !rd_act) begin
        serving       <= 1'b0;
        host_rdata_en <= 1'b0;
      end
      if (serving && !rd_act) begin
        pf_pend <= 1'b1;
        pf_next <= last_addr + WORD_W'(1);
      end else if (pf_taken || (f_start && demand)) begin
        pf_pend <= 1'b0;
      end
    end
  end

  // R2: a write into an empty register adds no wait state
  a_r2_post_no_wait: assert property (@(posedge clk) disable iff (rst)
    cap |=> host_ready);
  // R5: read data only appears after the grant was seen
  a_r5_serve_after_grant: assert property (@(posedge clk) disable iff (rst)
    $rose(host_rdata_en) |-> $past(pb_gnt));
  // R11: driven read word stays stable until the strobe drops
  a_r11_data_held: assert property (@(posedge clk) disable iff (rst)
    (host_rdata_en && $past(host_rdata_en)) |-> $stable(host_rdata));
endmodule

// File: tb/test_shm_bridge.sv
module test_shm_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int BYTE_W = 8;
  localparam int WORD_W = ADDR_W - 1;
  localparam int NW = 1 << WORD_W;
  localparam int NB = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [WORD_W-1:0] host_addr = '0;
  logic host_sel = 1'b0, host_rd = 1'b0, host_wr = 1'b0, host_refresh = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic host_rdata_en, host_ready, pb_req, pb_rd, pb_wr;
  logic pb_gnt = 1'b1, pb_inval = 1'b0;
  logic [ADDR_W-1:0] pb_addr;
  logic [7:0] pb_wdata, pb_rdata;

  logic [7:0] mem [NB];
  logic [15:0] expw [NW];
  logic agent_we = 1'b0;
  logic [ADDR_W-1:0] agent_addr = '0;
  logic [7:0] agent_data = '0;
  int checks = 0, fails = 0, wr_strobes = 0, bad_gnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shm_bridge #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_shm_bridge (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_sel(host_sel),
    .host_rd(host_rd), .host_wr(host_wr), .host_refresh(host_refresh),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdata_en(host_rdata_en),
    .host_ready(host_ready), .pb_req(pb_req), .pb_gnt(pb_gnt), .pb_addr(pb_addr),
    .pb_wdata(pb_wdata), .pb_rdata(pb_rdata), .pb_rd(pb_rd), .pb_wr(pb_wr),
    .pb_inval(pb_inval)
  );

  function automatic logic [15:0] seedw(input int w);
    return {8'((w * 5) + 7), 8'((w * 3) + 1)};
  endfunction

  // Byte-wide synchronous SRAM with a second writer standing in for another agent
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) mem[i] <= (i % 2 == 0) ? seedw(i / 2)[7:0] : seedw(i / 2)[15:8];
    end else begin
      if (pb_wr) mem[pb_addr] <= pb_wdata;
      if (agent_we) mem[agent_addr] <= agent_data;
      if (pb_rd) pb_rdata <= mem[pb_addr];
      if (pb_wr) wr_strobes <= wr_strobes + 1;
    end
  end

  always @(negedge clk) if (!rst && (pb_rd || pb_wr) && !pb_gnt) bad_gnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input int w, input logic [15:0] d, output int waits);
    @(negedge clk);
    host_addr = WORD_W'(w); host_wdata = d; host_sel = 1'b1; host_wr = 1'b1;
    waits = 0;
    forever begin
      @(posedge clk); @(negedge clk);
      if (host_ready) break;
      waits++;
      if (waits > 4000) break;
    end
    host_wr = 1'b0; host_sel = 1'b0;
    expw[w] = d;
  endtask

  task automatic host_read(input int w, input bit keep, output logic [15:0] d, output int waits);
    @(negedge clk);
    host_addr = WORD_W'(w); host_sel = 1'b1; host_rd = 1'b1;
    waits = 0;
    forever begin
      @(posedge clk); @(negedge clk);
      if (host_ready && host_rdata_en) break;
      waits++;
      if (waits > 4000) break;
    end
    d = host_rdata;
    if (!keep) begin host_rd = 1'b0; host_sel = 1'b0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int waits, s;
    for (int i = 0; i < NW; i++) expw[i] = seedw(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(host_ready == 1'b1, "R1 ready", 32'(host_ready), 1);
    chk(host_rdata_en == 1'b0, "R1 rdata_en", 32'(host_rdata_en), 0);
    chk({pb_req, pb_rd, pb_wr} == 3'b000, "R1 bus idle", 32'({pb_req, pb_rd, pb_wr}), 0);

    // R2 / R3 posted write, byte placement
    host_write(5, 16'hA55A, waits);
    chk(waits == 0, "R2 write waits", 32'(waits), 0);
    idle(6);
    chk(mem[10] == 8'h5A, "R3 low byte at even", 32'(mem[10]), 32'h5A);
    chk(mem[11] == 8'hA5, "R3 high byte at odd", 32'(mem[11]), 32'hA5);

    // R4 second write stalls while first cannot drain
    pb_gnt = 1'b0;
    host_write(6, 16'h1234, waits);
    chk(waits == 0, "R2 write into empty holding", 32'(waits), 0);
    idle(1);
    fork
      host_write(7, 16'h5678, waits);
      begin
        idle(10);
        chk(host_ready == 1'b0, "R4 ready low while full", 32'(host_ready), 0);
        pb_gnt = 1'b1;
      end
    join
    chk(waits >= 10, "R4 write stalled", 32'(waits), 10);
    idle(10);
    chk({mem[13], mem[12]} == 16'h1234, "R3 first word drained", 32'({mem[13], mem[12]}), 32'h1234);
    chk({mem[15], mem[14]} == 16'h5678, "R4 second word drained", 32'({mem[15], mem[14]}), 32'h5678);

    // R12 refresh and deselect block host cycles
    s = wr_strobes;
    @(negedge clk);
    host_refresh = 1'b1; host_sel = 1'b1; host_wr = 1'b1; host_addr = 7'd9; host_wdata = 16'hFFFF;
    idle(8);
    chk(host_ready == 1'b1, "R12 ready during refresh write", 32'(host_ready), 1);
    host_wr = 1'b0; host_rd = 1'b1;
    idle(8);
    chk(host_rdata_en == 1'b0, "R12 no data during refresh read", 32'(host_rdata_en), 0);
    chk(host_ready == 1'b1, "R12 ready during refresh read", 32'(host_ready), 1);
    host_rd = 1'b0; host_refresh = 1'b0; host_sel = 1'b0; host_wr = 1'b1;
    idle(8);
    host_wr = 1'b0;
    idle(8);
    chk(wr_strobes == s, "R12 no SRAM write", 32'(wr_strobes), 32'(s));
    chk({mem[19], mem[18]} == expw[9], "R12 word unchanged", 32'({mem[19], mem[18]}), 32'(expw[9]));

    // R5 read held off by missing grant
    pb_gnt = 1'b0;
    fork
      host_read(20, 1'b0, d, waits);
      begin
        idle(8);
        chk(pb_req == 1'b1, "R5 request raised", 32'(pb_req), 1);
        chk(host_ready == 1'b0, "R5 ready low without grant", 32'(host_ready), 0);
        pb_gnt = 1'b1;
      end
    join
    chk(waits >= 8, "R5 read waits", 32'(waits), 8);
    chk(d == expw[20], "R5 read data", 32'(d), 32'(expw[20]));
    idle(8);

    // Fill the window with a computed pattern
    for (int w = 0; w < NW; w++) begin
      host_write(w, 16'(w * 257) ^ 16'h3C96, waits);
      idle(1);
    end
    idle(8);

    // R6 / R7 sequential sweep: first a miss, the rest prefetch hits
    for (int w = 0; w < NW; w++) begin
      host_read(w, 1'b0, d, waits);
      chk(d == expw[w], "R6 sequential data", 32'(d), 32'(expw[w]));
      if (w == 0) chk(waits > 0, "R6 miss waits", 32'(waits), 1);
      else chk(waits == 0, "R7 prefetch hit no wait", 32'(waits), 0);
      idle(8);
    end
    // R8 prefetch wraps to word 0
    host_read(0, 1'b0, d, waits);
    chk(waits == 0, "R8 wrap prefetch", 32'(waits), 0);
    chk(d == expw[0], "R8 wrap data", 32'(d), 32'(expw[0]));
    idle(8);

    // R6 strided reads all miss
    for (int k = 1; k <= 40; k++) begin
      int w;
      w = (k * 37) % NW;
      host_read(w, 1'b0, d, waits);
      chk(d == expw[w], "R6 strided data", 32'(d), 32'(expw[w]));
      chk(waits > 0, "R6 strided miss", 32'(waits), 1);
      idle(3);
    end

    // R11 data held until strobe drops
    host_read(33, 1'b1, d, waits);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(host_rdata_en && host_rdata == expw[33], "R11 data held", 32'(host_rdata), 32'(expw[33]));
    end
    host_rd = 1'b0; host_sel = 1'b0;
    @(negedge clk);
    chk(host_rdata_en == 1'b0, "R11 enable released", 32'(host_rdata_en), 0);
    idle(8);

    // R9 invalidate after another agent changes the prefetched word
    host_read(40, 1'b0, d, waits);
    idle(8);
    @(negedge clk);
    agent_we = 1'b1; agent_addr = 8'd82; agent_data = 8'hC3;
    @(negedge clk);
    agent_addr = 8'd83; agent_data = 8'h3C;
    @(negedge clk);
    agent_we = 1'b0; pb_inval = 1'b1;
    @(negedge clk);
    pb_inval = 1'b0;
    expw[41] = 16'h3CC3;
    host_read(41, 1'b0, d, waits);
    chk(waits > 0, "R9 refetch after invalidate", 32'(waits), 1);
    chk(d == 16'h3CC3, "R9 fresh data", 32'(d), 32'h3CC3);
    idle(8);

    // R10 read right after a posted write to the prefetched word
    host_read(50, 1'b0, d, waits);
    idle(8);
    host_write(51, 16'hBEEF, waits);
    host_read(51, 1'b0, d, waits);
    chk(d == 16'hBEEF, "R10 read sees posted write", 32'(d), 32'hBEEF);
    idle(8);
    chk({mem[103], mem[102]} == 16'hBEEF, "R10 word in SRAM", 32'({mem[103], mem[102]}), 32'hBEEF);

    chk(bad_gnt == 0, "R5 strobes only with grant", 32'(bad_gnt), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule